// File: doc/BRIEF.md
# Descriptor-Chained Audio Stream DMA Channel

This block is one DMA channel that carries audio sample words between system memory and a codec port. It works through a ring of descriptors held in memory. Each descriptor occupies three consecutive 32-bit words. The first is the buffer address. The second is a count word, which holds an interrupt-enable flag and a byte count. The third is the address of the following descriptor. Software writes the address of the first descriptor into the channel. It then writes a control word with the active bit set. From that point the channel fetches each descriptor, moves the buffer bytes one 32-bit word at a time through a FIFO window, and goes on to the next descriptor. When a block completes whose descriptor had the flag set, the channel raises an interrupt status bit.

The control word carries four things: the direction (playback reads memory and feeds the codec; capture takes codec words and writes memory), a load bit that empties the FIFO, a high-water mark counted in halfwords, and the two bounds of the FIFO window counted in doublewords. The window lies inside a shared word store, so two channels can split one store. Memory traffic only starts once the FIFO fill level has passed the high-water mark. In playback the channel refills while the fill is below the mark. In capture it drains while the fill is above the mark.

Top module: `audma_channel`

## Requirements
- R1: After reset the channel is idle. mem_req, smp_valid, cap_ready and irq are low, and the registers at addresses 0, 1 and 2 read as zero.
- R2: A register write to address 0 sets the descriptor address. A later control write (address 1) with the active bit (bit 1) set makes the channel read memory at that address, then at +4, then at +8, in that order.
- R3: In the count word, bit 31 is the interrupt-enable flag and bits 30:0 are the byte count. Data moves one 32-bit word per access, at the buffer address and then in 4-byte steps, and the block ends once the count is used up.
- R4: When a block ends, the channel fetches the descriptor at that block's next address. A ring whose last descriptor points back to the first repeats without end.
- R5: The interrupt status (control read bit 0, and the irq output) is set when a block completes whose descriptor has bit 31 set. A completed block whose descriptor has bit 31 clear leaves it unchanged.
- R6: A read of the control register returns the status and then clears it. A block completion in the same cycle takes priority over the clear.
- R7: The control word fields are: bit 2 receive, bit 3 load, bits 15:8 high-water mark in halfwords, bits 23:16 window begin in doublewords, bits 31:24 window end in doublewords. These fields read back unchanged. The window holds (end-begin)*2 words.
- R8: In playback the channel issues a data read only while the FIFO fill in halfwords is below the high-water mark. The codec receives the words in memory order.
- R9: In capture the channel accepts codec words while the window is not full. It issues a memory write only while the fill in halfwords is above the high-water mark, and the words are written in arrival order.
- R10: A control write with only the load bit set stops the channel. No new memory requests are made, smp_valid falls, the buffer pointer stops moving and the FIFO is emptied.
- R11: Register address 2 reads the byte address of the next data access in the current block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a control read clears the status) |
| reg_addr | input | 2 | 0 descriptor address, 1 control, 2 buffer pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| irq | output | 1 | Interrupt status |
| smp_valid | output | 1 | Playback word offered to the codec |
| smp_data | output | 32 | Playback word |
| smp_ready | input | 1 | Codec takes the playback word |
| cap_valid | input | 1 | Codec offers a capture word |
| cap_data | input | 32 | Capture word |
| cap_ready | output | 1 | Channel accepts the capture word |

## Verification
The hardest part to reach is a chain of thresholds and completions that must line up: exactly when a block ends, whether its interrupt flag is set, and where the high-water mark stops the refill. The bench reaches it by stalling the codec and then releasing an exact number of playback words at a time. Each release lets the channel fetch a known number of words before the mark stops it again, so the end of a flagged block, the end of an unflagged block, and the buffer pointer at each stop fall on known cycles. For capture, the bench holds back write acknowledges until the window is full. This shows the ready drop at exactly four words, and then shows that the drain stops with two words left.

// File: rtl/audma_pkg.sv
package audma_pkg;

  // control word bit positions (bit 0 is the read-only status)
  localparam int CTL_INT_BIT = 0;
  localparam int CTL_ACT_BIT = 1;
  localparam int CTL_RCV_BIT = 2;
  localparam int CTL_LD_BIT  = 3;
  localparam int CTL_HWM_LSB = 8;
  localparam int CTL_BEG_LSB = 16;
  localparam int CTL_END_LSB = 24;

  // count word layout
  localparam int CNT_IE_BIT = 31;
  localparam int CNT_LEN_W  = 31;

  // FIFO fill / pointer width covers any window an 8-bit bound can describe
  localparam int FILL_W = 9;

  localparam logic [1:0] RA_DPTR = 2'd0;
  localparam logic [1:0] RA_CTRL = 2'd1;
  localparam logic [1:0] RA_BPTR = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BUF,
    ST_CNT,
    ST_NXT,
    ST_XFER
  } seq_state_e;

  typedef struct packed {
    logic [7:0] fend;
    logic [7:0] fbeg;
    logic [7:0] hwm;
    logic       ld;
    logic       rcv;
    logic       act;
  } ctl_t;

endpackage

// File: rtl/audma_regs.sv
module audma_regs
  import audma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  ctl_t ctl_wdata,
  input  logic ctl_rd,
  input  logic blk_irq,
  output ctl_t ctl,
  output logic int_st,
  output logic start,
  output logic flush
);

  ctl_t ctl_q, ctl_d;
  logic int_q, int_d;
  logic start_q, flush_q;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) ctl_d = ctl_wdata;
    int_d = int_q;
    if (ctl_rd)  int_d = 1'b0;
    if (blk_irq) int_d = 1'b1;
  end

  // start and flush act one cycle after the write, when the new word is live
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      int_q   <= 1'b0;
      start_q <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      if (ctl_wr) ctl_q <= ctl_d;
      int_q   <= int_d;
      start_q <= ctl_wr && ctl_wdata.act;
      flush_q <= ctl_wr && ctl_wdata.ld;
    end
  end

  assign ctl    = ctl_q;
  assign int_st = int_q;
  assign start  = start_q;
  assign flush  = flush_q;

  assert_irq_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_irq |=> int_q);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && !blk_irq) |=> !int_q);

endmodule

// File: rtl/audma_fifo.sv
module audma_fifo
  import audma_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        win_beg,
  input  logic [7:0]        win_end,
  input  logic              flush,
  input  logic              push,
  input  logic [DW-1:0]     wdata,
  input  logic              pop,
  output logic [DW-1:0]     rdata,
  output logic [FILL_W-1:0] fill,
  output logic              full,
  output logic              empty
);

  localparam int IW = $clog2(DEPTH);

  logic [DW-1:0]     store [DEPTH];
  logic [FILL_W-1:0] wp_q, wp_d, rp_q, rp_d, fill_q, fill_d;
  logic [FILL_W-1:0] base_w, last_w, cap_w;

  always_comb begin
    base_w = {win_beg, 1'b0};
    last_w = {win_end, 1'b0} - FILL_W'(1);
    cap_w  = (win_end > win_beg) ? {win_end - win_beg, 1'b0} : '0;
  end

  assign full  = (fill_q >= cap_w);
  assign empty = (fill_q == '0);
  assign fill  = fill_q;
  assign rdata = store[rp_q[IW-1:0]];

  always_comb begin
    wp_d   = wp_q;
    rp_d   = rp_q;
    fill_d = fill_q;
    if (flush) begin
      wp_d   = base_w;
      rp_d   = base_w;
      fill_d = '0;
    end else begin
      if (push) wp_d = (wp_q == last_w) ? base_w : wp_q + FILL_W'(1);
      if (pop)  rp_d = (rp_q == last_w) ? base_w : rp_q + FILL_W'(1);
      fill_d = fill_q + FILL_W'(push) - FILL_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) store[wp_q[IW-1:0]] <= wdata;
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> !full);

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |-> !empty);

endmodule

// File: rtl/audma_seq.sv
module audma_seq
  import audma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic              rcv,
  input  logic [7:0]        hwm,
  input  logic              start,
  input  logic              dptr_wr,
  input  logic [AW-1:0]     dptr_wdata,
  input  logic [FILL_W-1:0] fill,
  input  logic              full,
  input  logic              empty,
  input  logic [DW-1:0]     fifo_rdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              fifo_push,
  output logic              fifo_pop,
  output logic              blk_irq,
  output logic [AW-1:0]     desc_addr,
  output logic [AW-1:0]     cur_addr
);

  localparam int STEP = DW / 8;

  seq_state_e           st_q, st_d;
  logic [AW-1:0]        desc_q, desc_d, buf_q, buf_d, nxt_q, nxt_d;
  logic [CNT_LEN_W-1:0] rem_q, rem_d;
  logic                 ie_q, ie_d, busy_q, busy_d;
  logic [FILL_W:0]      fill_hw;
  logic                 want;

  always_comb begin
    fill_hw = {fill, 1'b0};
    want    = rcv ? ((fill_hw > {2'b0, hwm}) && !empty)
                  : ((fill_hw < {2'b0, hwm}) && !full);
  end

  always_comb begin
    st_d      = st_q;
    desc_d    = desc_q;
    buf_d     = buf_q;
    nxt_d     = nxt_q;
    rem_d     = rem_q;
    ie_d      = ie_q;
    busy_d    = busy_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = buf_q;
    fifo_push = 1'b0;
    fifo_pop  = 1'b0;
    blk_irq   = 1'b0;
    if (dptr_wr) desc_d = dptr_wdata;
    case (st_q)
      ST_BUF: begin
        mem_req  = 1'b1;
        mem_addr = desc_q;
        if (mem_ack) begin
          buf_d = mem_rdata[AW-1:0];
          st_d  = ST_CNT;
        end
      end
      ST_CNT: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + AW'(STEP);
        if (mem_ack) begin
          rem_d = mem_rdata[CNT_LEN_W-1:0];
          ie_d  = mem_rdata[CNT_IE_BIT];
          st_d  = ST_NXT;
        end
      end
      ST_NXT: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + AW'(2 * STEP);
        if (mem_ack) begin
          nxt_d = mem_rdata[AW-1:0];
          st_d  = ST_XFER;
        end
      end
      ST_XFER: begin
        if (busy_q) begin
          mem_req = 1'b1;
          mem_we  = rcv;
          if (mem_ack) begin
            busy_d    = 1'b0;
            buf_d     = buf_q + AW'(STEP);
            rem_d     = (rem_q > CNT_LEN_W'(STEP)) ? rem_q - CNT_LEN_W'(STEP) : '0;
            fifo_push = !rcv;
            fifo_pop  = rcv;
          end
        end else if (rem_q == '0) begin
          blk_irq = ie_q;
          desc_d  = nxt_q;
          st_d    = ST_BUF;
        end else if (want) begin
          busy_d = 1'b1;
        end
      end
      default: ;
    endcase
    if (start) begin
      st_d   = ST_BUF;
      busy_d = 1'b0;
    end
    if (!act) begin
      st_d      = ST_IDLE;
      busy_d    = 1'b0;
      mem_req   = 1'b0;
      fifo_push = 1'b0;
      fifo_pop  = 1'b0;
      blk_irq   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      desc_q <= '0;
      buf_q  <= '0;
      nxt_q  <= '0;
      rem_q  <= '0;
      ie_q   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      desc_q <= desc_d;
      buf_q  <= buf_d;
      nxt_q  <= nxt_d;
      rem_q  <= rem_d;
      ie_q   <= ie_d;
      busy_q <= busy_d;
    end
  end

  assign mem_wdata = fifo_rdata;
  assign desc_addr = desc_q;
  assign cur_addr  = buf_q;

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (!act || start || (mem_req && $stable(mem_addr))));

  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_XFER && !start) |=> (st_q != ST_XFER || rem_q <= $past(rem_q)));

  assert_follow_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_XFER && !busy_q && rem_q == '0 && act && !start)
      |=> (st_q == ST_BUF && desc_q == $past(nxt_q)));

endmodule

// File: rtl/audma_channel.sv
module audma_channel
  import audma_pkg::*;
#(
  parameter int FIFO_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        irq,
  output logic        smp_valid,
  output logic [31:0] smp_data,
  input  logic        smp_ready,
  input  logic        cap_valid,
  input  logic [31:0] cap_data,
  output logic        cap_ready
);

  localparam int AW = 32;
  localparam int DW = 32;

  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  ctl_t              ctl, ctl_w;
  logic              int_st, start, flush, blk_irq;
  logic [FILL_W-1:0] fill;
  logic              full, empty;
  logic [DW-1:0]     fifo_rdata, fifo_wdata;
  logic              seq_push, seq_pop, fifo_push, fifo_pop;
  logic [AW-1:0]     desc_addr, cur_addr;

  always_comb begin
    ctl_w.fend = reg_wdata[CTL_END_LSB +: 8];
    ctl_w.fbeg = reg_wdata[CTL_BEG_LSB +: 8];
    ctl_w.hwm  = reg_wdata[CTL_HWM_LSB +: 8];
    ctl_w.ld   = reg_wdata[CTL_LD_BIT];
    ctl_w.rcv  = reg_wdata[CTL_RCV_BIT];
    ctl_w.act  = reg_wdata[CTL_ACT_BIT];
  end

  audma_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .ctl_wr    (reg_wr && reg_addr == RA_CTRL),
    .ctl_wdata (ctl_w),
    .ctl_rd    (reg_rd && reg_addr == RA_CTRL),
    .blk_irq   (blk_irq),
    .ctl       (ctl),
    .int_st    (int_st),
    .start     (start),
    .flush     (flush)
  );

  assign smp_valid  = ctl.act && !ctl.rcv && !empty;
  assign cap_ready  = ctl.act && ctl.rcv && !full;
  assign smp_data   = fifo_rdata;
  assign fifo_push  = seq_push || (cap_valid && cap_ready);
  assign fifo_pop   = seq_pop || (smp_valid && smp_ready);
  assign fifo_wdata = ctl.rcv ? cap_data : mem_rdata;

  audma_fifo #(.DEPTH(FIFO_WORDS), .DW(DW)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .win_beg (ctl.fbeg),
    .win_end (ctl.fend),
    .flush   (flush),
    .push    (fifo_push),
    .wdata   (fifo_wdata),
    .pop     (fifo_pop),
    .rdata   (fifo_rdata),
    .fill    (fill),
    .full    (full),
    .empty   (empty)
  );

  audma_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .act        (ctl.act),
    .rcv        (ctl.rcv),
    .hwm        (ctl.hwm),
    .start      (start),
    .dptr_wr    (reg_wr && reg_addr == RA_DPTR),
    .dptr_wdata (reg_wdata),
    .fill       (fill),
    .full       (full),
    .empty      (empty),
    .fifo_rdata (fifo_rdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .fifo_push  (seq_push),
    .fifo_pop   (seq_pop),
    .blk_irq    (blk_irq),
    .desc_addr  (desc_addr),
    .cur_addr   (cur_addr)
  );

  assign irq = int_st;

  always_comb begin
    case (reg_addr)
      RA_DPTR: reg_rdata = desc_addr;
      RA_CTRL: reg_rdata = {ctl.fend, ctl.fbeg, ctl.hwm, 4'b0, ctl.ld, ctl.rcv, ctl.act, int_st};
      RA_BPTR: reg_rdata = cur_addr;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: tb/test_audma_channel.sv
module test_audma_channel;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq, smp_valid, smp_ready, cap_valid, cap_ready;
  logic [31:0] smp_data, cap_data;

  always #2 clk = ~clk;

  audma_channel i_audma_channel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .irq(irq), .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
    .cap_valid(cap_valid), .cap_data(cap_data), .cap_ready(cap_ready)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] exp_smp [$];
  logic [63:0] exp_wr [$];
  logic [31:0] rd_log [$];
  int smp_budget = 0;
  int data_rd_cnt = 0;
  int wr_cnt = 0;
  int req_cycles = 0;
  int cap_idx = 0;
  logic mem_hold = 1'b0;

  task automatic chk(string req, logic [31:0] act_v, logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  function automatic logic [31:0] ctl_word(bit act, bit rcv, bit ld,
                                           logic [7:0] hw, logic [7:0] b, logic [7:0] e);
    return {e, b, hw, 4'b0, ld, rcv, act, 1'b0};
  endfunction

  // memory model and write monitor
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req) req_cycles++;
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req && rst_n && !(mem_we && mem_hold)) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          mem[mem_addr[11:2]] = mem_wdata;
          wr_cnt++;
          if (exp_wr.size() == 0) chk("R9 unexpected write", mem_addr, 32'hxxxxxxxx);
          else begin
            logic [63:0] e;
            e = exp_wr.pop_front();
            chk("R3 capture write address", mem_addr, e[63:32]);
            chk("R9 capture write order", mem_wdata, e[31:0]);
          end
        end else begin
          mem_rdata = mem[mem_addr[11:2]];
          rd_log.push_back(mem_addr);
          if (mem_addr >= 32'h200) data_rd_cnt++;
        end
      end
    end
  end

  // playback codec monitor
  initial begin
    smp_ready = 1'b0;
    forever begin
      @(negedge clk);
      smp_ready = (smp_budget != 0);
      #1;
      if (smp_valid && smp_ready) begin
        if (exp_smp.size() == 0) chk("R8 unexpected sample", smp_data, 32'hxxxxxxxx);
        else chk("R3 R8 playback sample order", smp_data, exp_smp.pop_front());
        if (smp_budget > 0) smp_budget--;
      end
    end
  end

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic logic [31:0] cap_addr(int idx);
    return (((idx / 2) % 2) != 0 ? 32'h700 : 32'h600) + 32'(4 * (idx % 2));
  endfunction

  task automatic cap_send(logic [31:0] d);
    @(negedge clk);
    cap_valid = 1'b1; cap_data = d;
    #1;
    while (!cap_ready) begin @(negedge clk); #1; end
    exp_wr.push_back({cap_addr(cap_idx), d});
    cap_idx++;
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  task automatic expect_lap();
    for (int i = 0; i < 4; i++) exp_smp.push_back(32'hA000_0000 + 32'(i));
    for (int i = 0; i < 2; i++) exp_smp.push_back(32'hB000_0000 + 32'(i));
    for (int i = 0; i < 3; i++) exp_smp.push_back(32'hC000_0000 + 32'(i));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int mark;
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    cap_valid = 0; cap_data = 0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    // playback ring
    mem[32'h100 >> 2] = 32'h200; mem[32'h104 >> 2] = 32'h8000_0010; mem[32'h108 >> 2] = 32'h10C;
    mem[32'h10C >> 2] = 32'h300; mem[32'h110 >> 2] = 32'h0000_0008; mem[32'h114 >> 2] = 32'h118;
    mem[32'h118 >> 2] = 32'h400; mem[32'h11C >> 2] = 32'h8000_000C; mem[32'h120 >> 2] = 32'h100;
    for (int i = 0; i < 4; i++) mem[(32'h200 >> 2) + i] = 32'hA000_0000 + 32'(i);
    for (int i = 0; i < 2; i++) mem[(32'h300 >> 2) + i] = 32'hB000_0000 + 32'(i);
    for (int i = 0; i < 3; i++) mem[(32'h400 >> 2) + i] = 32'hC000_0000 + 32'(i);
    // capture ring
    mem[32'h140 >> 2] = 32'h600; mem[32'h144 >> 2] = 32'h8000_0008; mem[32'h148 >> 2] = 32'h14C;
    mem[32'h14C >> 2] = 32'h700; mem[32'h150 >> 2] = 32'h8000_0008; mem[32'h154 >> 2] = 32'h140;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 mem_req idle", {31'b0, mem_req}, 32'h0);
    chk("R1 smp_valid idle", {31'b0, smp_valid}, 32'h0);
    chk("R1 cap_ready idle", {31'b0, cap_ready}, 32'h0);
    chk("R1 irq idle", {31'b0, irq}, 32'h0);
    reg_read(2'd0, v); chk("R1 descriptor reg", v, 32'h0);
    reg_read(2'd1, v); chk("R1 control reg", v, 32'h0);
    reg_read(2'd2, v); chk("R1 buffer pointer reg", v, 32'h0);

    // playback start with the codec stalled
    expect_lap(); expect_lap();
    smp_budget = 0;
    reg_write(2'd0, 32'h100);
    reg_write(2'd1, ctl_word(1, 0, 1, 8'd4, 8'd0, 8'd2));
    repeat (40) @(negedge clk);
    reg_read(2'd1, v); chk("R7 control readback", v, 32'h0200_040A);
    chk("R2 first fetch", rd_log[0], 32'h100);
    chk("R2 second fetch", rd_log[1], 32'h104);
    chk("R2 third fetch", rd_log[2], 32'h108);
    chk("R8 reads stop at high-water", 32'(data_rd_cnt), 32'd2);
    chk("R8 word offered", {31'b0, smp_valid}, 32'h1);
    reg_read(2'd2, v); chk("R11 pointer after two words", v, 32'h208);

    smp_budget = 2;
    repeat (40) @(negedge clk);
    chk("R5 irq after flagged block", {31'b0, irq}, 32'h1);
    reg_read(2'd1, v); chk("R5 status bit set", {31'b0, v[0]}, 32'h1);
    reg_read(2'd1, v); chk("R6 status cleared by read", {31'b0, v[0]}, 32'h0);
    reg_read(2'd2, v); chk("R11 pointer at next block", v, 32'h300);
    reg_read(2'd0, v); chk("R4 descriptor followed", v, 32'h10C);

    smp_budget = 2;
    repeat (40) @(negedge clk);
    chk("R5 unflagged block leaves irq low", {31'b0, irq}, 32'h0);
    reg_read(2'd2, v); chk("R11 pointer in third block", v, 32'h400);
    reg_read(2'd0, v); chk("R4 chain second hop", v, 32'h118);

    smp_budget = 14;
    repeat (300) @(negedge clk);
    chk("R4 ring wrapped twice", 32'(exp_smp.size()), 32'd0);

    // stop with only the load bit
    reg_write(2'd1, 32'h0000_0008);
    repeat (3) @(negedge clk);
    mark = req_cycles;
    reg_read(2'd2, v);
    repeat (30) @(negedge clk);
    reg_read(2'd2, v2);
    chk("R10 no requests after stop", 32'(req_cycles), 32'(mark));
    chk("R10 pointer frozen", v2, v);
    chk("R10 smp_valid low", {31'b0, smp_valid}, 32'h0);

    // capture
    reg_read(2'd1, v);
    smp_budget = 0;
    mem_hold = 1'b1;
    reg_write(2'd0, 32'h140);
    reg_write(2'd1, ctl_word(1, 1, 1, 8'd4, 8'd2, 8'd4));
    repeat (20) @(negedge clk);
    for (int i = 0; i < 4; i++) cap_send(32'hD000_0000 + 32'(i));
    #1;
    chk("R7 R9 window full at four words", {31'b0, cap_ready}, 32'h0);
    chk("R9 no write while held", 32'(wr_cnt), 32'd0);
    mem_hold = 1'b0;
    repeat (30) @(negedge clk);
    chk("R9 drain stops at high-water", 32'(wr_cnt), 32'd2);
    for (int i = 4; i < 12; i++) cap_send(32'hD000_0000 + 32'(i));
    repeat (30) @(negedge clk);
    chk("R9 writes above high-water", 32'(wr_cnt), 32'd10);
    chk("R9 two words remain", 32'(exp_wr.size()), 32'd2);
    chk("R5 capture block irq", {31'b0, irq}, 32'h1);
    reg_read(2'd2, v); chk("R11 capture pointer", v, 32'h700);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule